// File: doc/BRIEF.md
# In-Order Pipeline Hazard Controller

This block is the central control for a five-stage in-order integer pipeline. The stages, oldest last, are fetch (IF), register read (RF), execute (EX), data cache (DC) and writeback (WB). Every cycle it reads short descriptors of the instructions in RF, EX, DC and WB, the multiply/divide busy flag, the two cache-miss flags and an exception request. From these it drives per-stage hold and flush controls, a bubble-insert strobe for EX, a fetch-redirect strobe, the register-file write enable and the operand-source selects for the instruction in EX. All outputs are combinational, so they apply in the same cycle as the inputs that cause them.

It handles three kinds of disruption. A slip holds only the young stages, IF and RF, and puts a no-op into EX while DC and WB drain. A stall freezes all five stages until the cache miss is resolved. An exception cancels the faulting stage and every younger stage, and fetch is redirected to the exception vector. A taken branch never cancels anything: the delay-slot instruction behind it runs. The datapath, register file, caches and multiply/divide unit lie outside the block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: Hold and flush bit i maps to a stage: bit 0 IF, bit 1 RF, bit 2 EX, bit 3 DC, bit 4 WB. With no hazard, no miss and no exception, hold, flush, ex_bubble and redirect are all zero. Hold and flush are never set for the same stage.
- R2: A load-use slip occurs when a valid load in EX writes a nonzero register that a valid RF instruction reads on either source. Without a stall or exception, it gives hold = 5'b00011 and ex_bubble = 1.
- R3: A valid RF move-from-HI/LO instruction slips, with the same hold and ex_bubble as R2, while md_busy is 1. It goes ahead without a slip once md_busy is 0.
- R4: An instruction or data cache miss, with no exception, gives hold = 5'b11111 and ex_bubble = 0. This holds even when a slip condition is also present.
- R5: When exc_req is 1, flush bit i is set for every stage i <= exc_stage. Values of exc_stage above 4 flush all stages. redirect is 1, and hold and ex_bubble are 0, whatever the stall and slip conditions are.
- R6: br_taken has no effect on any output. With no exception, flush stays zero, so the delay-slot instruction is not cancelled.
- R7: Each EX operand select (byp_a for source A, byp_b for source B) uses 0 = register file, 1 = DC result, 2 = WB result, 3 = constant zero. A matching valid, writing DC producer is preferred over a matching WB producer.
- R8: A source register number of 0 always selects 3 (zero), even when a producer names register 0.
- R9: rf_wr_en is 1 only when WB is valid, writes, names a nonzero register, and is neither flushed nor held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| rf_valid | input | 1 | RF holds a real instruction |
| rf_src_a | input | REG_W | RF source register A |
| rf_src_b | input | REG_W | RF source register B |
| rf_is_mdmove | input | 1 | RF instruction moves from HI/LO |
| ex_valid | input | 1 | EX holds a real instruction |
| ex_src_a | input | REG_W | EX source register A |
| ex_src_b | input | REG_W | EX source register B |
| ex_dst | input | REG_W | EX destination register |
| ex_we | input | 1 | EX instruction writes a register |
| ex_is_load | input | 1 | EX instruction is a load |
| dc_valid | input | 1 | DC holds a real instruction |
| dc_dst | input | REG_W | DC destination register |
| dc_we | input | 1 | DC instruction writes a register |
| wb_valid | input | 1 | WB holds a real instruction |
| wb_dst | input | REG_W | WB destination register |
| wb_we | input | 1 | WB instruction writes a register |
| md_busy | input | 1 | Multiply/divide result not ready |
| icache_miss | input | 1 | Instruction cache miss pending |
| dcache_miss | input | 1 | Data cache miss pending |
| br_taken | input | 1 | Taken branch or jump in EX |
| exc_req | input | 1 | Exception signalled this cycle |
| exc_stage | input | 3 | Faulting stage index (0 IF .. 4 WB) |
| hold | output | 5 | Per-stage hold, bit order as in R1 |
| flush | output | 5 | Per-stage cancel into a bubble with write enable cleared |
| ex_bubble | output | 1 | Insert a no-op into EX |
| redirect | output | 1 | Redirect fetch to the exception vector |
| byp_a | output | 2 | EX source A select |
| byp_b | output | 2 | EX source B select |
| rf_wr_en | output | 1 | Register-file write enable for the WB instruction |

## Verification
The embedded checks assume that the descriptor fields follow the rules of a real pipeline: a field only matters when its stage's valid bit is set, and exc_stage names a stage from 0 to 4 unless full flushing is wanted. They make no assumption about how the inputs combine, so a stall, a slip and an exception may all be present at once. The stimulus draws register numbers from a small range so that source and destination matches, and register 0, come up often. Misses and exceptions are drawn with modest probability so that every priority combination appears. exc_stage covers 0 to 7, which includes the out-of-range values that flush every stage.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSTG = 5;
  localparam int STG_IF = 0;
  localparam int STG_RF = 1;
  localparam int STG_EX = 2;
  localparam int STG_DC = 3;
  localparam int STG_WB = 4;

  typedef enum logic [1:0] {
    BYP_RF   = 2'd0,
    BYP_DC   = 2'd1,
    BYP_WB   = 2'd2,
    BYP_ZERO = 2'd3
  } byp_e;

  localparam logic [NSTG-1:0] HOLD_NONE  = '0;
  localparam logic [NSTG-1:0] HOLD_ALL   = '1;
  localparam logic [NSTG-1:0] HOLD_YOUNG = NSTG'((1 << (STG_RF + 1)) - 1);

  // Cancel mask: the faulting stage and every younger (lower-index) stage.
  function automatic logic [NSTG-1:0] cancel_mask(input logic req, input logic [2:0] stg);
    logic [NSTG-1:0] m;
    for (int i = 0; i < NSTG; i++) m[i] = req && (3'(i) <= stg);
    return m;
  endfunction
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] src,
  input  logic             dc_valid,
  input  logic             dc_we,
  input  logic [REG_W-1:0] dc_dst,
  input  logic             wb_valid,
  input  logic             wb_we,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       sel
);
  function automatic logic produces(input logic v, input logic we,
                                    input logic [REG_W-1:0] d, input logic [REG_W-1:0] s);
    return v && we && (d == s);
  endfunction

  logic src_zero, dc_hit, wb_hit;
  byp_e sel_e;

  assign src_zero = (src == '0);
  assign dc_hit   = produces(dc_valid, dc_we, dc_dst, src);
  assign wb_hit   = produces(wb_valid, wb_we, wb_dst, src);

  always_comb begin
    if (src_zero)    sel_e = BYP_ZERO;
    else if (dc_hit) sel_e = BYP_DC;
    else if (wb_hit) sel_e = BYP_WB;
    else             sel_e = BYP_RF;
  end
  assign sel = sel_e;

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == BYP_ZERO)); // R8
  AST_DC_OVER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_valid && dc_we && dc_dst == src && src != '0) |-> (sel == BYP_DC)); // R7
  AST_WB_SEL_HAS_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == BYP_WB) |-> (wb_valid && wb_we && wb_dst == src)); // R7
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_valid,
  input  logic [REG_W-1:0] rf_src_a,
  input  logic [REG_W-1:0] rf_src_b,
  input  logic             rf_is_mdmove,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic             md_busy,
  output logic             load_use,
  output logic             md_wait
);
  function automatic logic needs_reg(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
                                     input logic [REG_W-1:0] d);
    return (d != '0) && ((a == d) || (b == d));
  endfunction

  logic ex_load_wr;
  assign ex_load_wr = ex_valid && ex_is_load && ex_we;
  assign load_use   = rf_valid && ex_load_wr && needs_reg(rf_src_a, rf_src_b, ex_dst);
  assign md_wait    = rf_valid && rf_is_mdmove && md_busy;

  AST_LOADUSE_HAS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_use |-> (ex_valid && ex_is_load && rf_valid)); // R2
  AST_MDWAIT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!md_busy) |-> !md_wait); // R3
endmodule

// File: rtl/hz_ctrl_merge.sv
module hz_ctrl_merge
  import hz_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            slip,
  input  logic            exc_req,
  input  logic [2:0]      exc_stage,
  input  logic            br_taken,
  output logic [NSTG-1:0] hold,
  output logic [NSTG-1:0] flush,
  output logic            ex_bubble,
  output logic            redirect
);
  logic do_stall, do_slip;

  // Priority: exception over stall over slip.
  assign do_stall = stall && !exc_req;
  assign do_slip  = slip && !stall && !exc_req;

  always_comb begin
    if (do_stall)     hold = HOLD_ALL;
    else if (do_slip) hold = HOLD_YOUNG;
    else              hold = HOLD_NONE;
  end

  assign ex_bubble = do_slip;
  assign flush     = cancel_mask(exc_req, exc_stage);
  assign redirect  = exc_req;

  AST_HOLD_FLUSH_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold & flush) == '0); // R1
  AST_SLIP_YOUNG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> (!hold[STG_DC] && !hold[STG_WB] && hold[STG_RF] && hold[STG_IF])); // R2
  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !exc_req) |-> (&hold && !ex_bubble)); // R4
  AST_EXC_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (flush[STG_IF] && redirect && hold == '0 && !ex_bubble)); // R5
  AST_FLUSH_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush & (flush + NSTG'(1))) == '0); // R5
  AST_BRANCH_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (br_taken && !exc_req) |-> (flush == '0)); // R6
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_valid,
  input  logic [REG_W-1:0] rf_src_a,
  input  logic [REG_W-1:0] rf_src_b,
  input  logic             rf_is_mdmove,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic             dc_valid,
  input  logic [REG_W-1:0] dc_dst,
  input  logic             dc_we,
  input  logic             wb_valid,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_we,
  input  logic             md_busy,
  input  logic             icache_miss,
  input  logic             dcache_miss,
  input  logic             br_taken,
  input  logic             exc_req,
  input  logic [2:0]       exc_stage,
  output logic [4:0]       hold,
  output logic [4:0]       flush,
  output logic             ex_bubble,
  output logic             redirect,
  output logic [1:0]       byp_a,
  output logic [1:0]       byp_b,
  output logic             rf_wr_en
);
  localparam int NOPS = 2;

  logic load_use, md_wait, slip, stall;
  logic [REG_W-1:0] op_src [NOPS];
  logic [1:0]       op_sel [NOPS];

  assign stall = icache_miss || dcache_miss;
  assign slip  = load_use || md_wait;

  hz_interlock #(.REG_W(REG_W)) u_ilk (
    .clk(clk), .rst_n(rst_n),
    .rf_valid(rf_valid), .rf_src_a(rf_src_a), .rf_src_b(rf_src_b),
    .rf_is_mdmove(rf_is_mdmove),
    .ex_valid(ex_valid), .ex_dst(ex_dst), .ex_we(ex_we), .ex_is_load(ex_is_load),
    .md_busy(md_busy),
    .load_use(load_use), .md_wait(md_wait)
  );

  hz_ctrl_merge u_merge (
    .clk(clk), .rst_n(rst_n),
    .stall(stall), .slip(slip), .exc_req(exc_req), .exc_stage(exc_stage),
    .br_taken(br_taken),
    .hold(hold), .flush(flush), .ex_bubble(ex_bubble), .redirect(redirect)
  );

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_sel #(.REG_W(REG_W)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .src(op_src[g]),
      .dc_valid(dc_valid), .dc_we(dc_we), .dc_dst(dc_dst),
      .wb_valid(wb_valid), .wb_we(wb_we), .wb_dst(wb_dst),
      .sel(op_sel[g])
    );
  end

  assign byp_a = op_sel[0];
  assign byp_b = op_sel[1];

  assign rf_wr_en = wb_valid && wb_we && (wb_dst != '0) && !flush[STG_WB] && !hold[STG_WB];

  AST_NO_WRITE_CANCELLED: assert property (@(posedge clk) disable iff (!rst_n)
    (flush[STG_WB] || hold[STG_WB]) |-> !rf_wr_en); // R9
  AST_MD_SLIP_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    (md_wait && !stall && !exc_req) |-> ex_bubble); // R3
  AST_LOAD_SLIP_BUBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_use && !stall && !exc_req) |-> (ex_bubble && hold == 5'b00011)); // R2
endmodule

// File: tb/sim_pipe_hazard_ctrl.sv
module sim_pipe_hazard_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic rf_valid, rf_is_mdmove, ex_valid, ex_we, ex_is_load, dc_valid, dc_we;
  logic wb_valid, wb_we, md_busy, icache_miss, dcache_miss, br_taken, exc_req;
  logic [4:0] rf_src_a, rf_src_b, ex_src_a, ex_src_b, ex_dst, dc_dst, wb_dst;
  logic [2:0] exc_stage;
  logic [4:0] hold, flush;
  logic ex_bubble, redirect, rf_wr_en;
  logic [1:0] byp_a, byp_b;

  int checks = 0;
  int failures = 0;

  pipe_hazard_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .rf_valid(rf_valid), .rf_src_a(rf_src_a), .rf_src_b(rf_src_b), .rf_is_mdmove(rf_is_mdmove),
    .ex_valid(ex_valid), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst),
    .ex_we(ex_we), .ex_is_load(ex_is_load),
    .dc_valid(dc_valid), .dc_dst(dc_dst), .dc_we(dc_we),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_we(wb_we),
    .md_busy(md_busy), .icache_miss(icache_miss), .dcache_miss(dcache_miss),
    .br_taken(br_taken), .exc_req(exc_req), .exc_stage(exc_stage),
    .hold(hold), .flush(flush), .ex_bubble(ex_bubble), .redirect(redirect),
    .byp_a(byp_a), .byp_b(byp_b), .rf_wr_en(rf_wr_en)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    {rf_valid, rf_is_mdmove, ex_valid, ex_we, ex_is_load, dc_valid, dc_we} = '0;
    {wb_valid, wb_we, md_busy, icache_miss, dcache_miss, br_taken, exc_req} = '0;
    {rf_src_a, rf_src_b, ex_src_a, ex_src_b, ex_dst, dc_dst, wb_dst} = '0;
    exc_stage = '0;
  endtask

  function automatic int want_sel(input logic [4:0] s);
    if (s == 0) return 3;
    if (dc_valid && dc_we && dc_dst == s) return 1;
    if (wb_valid && wb_we && wb_dst == s) return 2;
    return 0;
  endfunction

  // Restates the requirements directly and compares every output.
  task automatic check_all();
    bit ld, md, st;
    int eh, ef, eb, ewr;
    string hreq, freq;
    ld = ex_valid && ex_is_load && ex_we && ex_dst != 0 && rf_valid &&
         (rf_src_a == ex_dst || rf_src_b == ex_dst);
    md = rf_valid && rf_is_mdmove && md_busy;
    st = icache_miss || dcache_miss;
    eh = 0; ef = 0; eb = 0;
    if (exc_req) begin
      for (int i = 0; i < 5; i++) if (i <= int'(exc_stage)) ef |= (1 << i);
    end else if (st) eh = 31;
    else if (ld || md) begin eh = 3; eb = 1; end
    ewr = (wb_valid && wb_we && wb_dst != 0 && ef[4] == 0 && eh[4] == 0) ? 1 : 0;
    hreq = exc_req ? "R5" : st ? "R4" : ld ? "R2" : md ? "R3" : "R1";
    freq = exc_req ? "R5" : br_taken ? "R6" : "R1";
    chk(hreq, "hold", int'(hold), eh);
    chk(hreq, "ex_bubble", int'(ex_bubble), eb);
    chk(freq, "flush", int'(flush), ef);
    chk(freq, "redirect", int'(redirect), int'(exc_req));
    chk(ex_src_a == 0 ? "R8" : "R7", "byp_a", int'(byp_a), want_sel(ex_src_a));
    chk(ex_src_b == 0 ? "R8" : "R7", "byp_b", int'(byp_b), want_sel(ex_src_b));
    chk("R9", "rf_wr_en", int'(rf_wr_en), ewr);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #2;
    chk("R1", "reset hold", int'(hold), 0);
    chk("R1", "reset flush", int'(flush), 0);
    check_all();

    // R2: load in EX writes r3, RF reads r3 on source B
    @(negedge clk); idle();
    ex_valid = 1; ex_is_load = 1; ex_we = 1; ex_dst = 3;
    rf_valid = 1; rf_src_a = 1; rf_src_b = 3;
    #2; chk("R2", "load-use hold", int'(hold), 5'b00011); check_all();

    // R2: load to r0 does not slip
    @(negedge clk); ex_dst = 0; rf_src_b = 0;
    #2; chk("R2", "r0 load no slip", int'(ex_bubble), 0); check_all();

    // R3: mdmove with busy, then not busy
    @(negedge clk); idle(); rf_valid = 1; rf_is_mdmove = 1; md_busy = 1;
    #2; chk("R3", "md busy bubble", int'(ex_bubble), 1); check_all();
    @(negedge clk); md_busy = 0;
    #2; chk("R3", "md ready no slip", int'(hold), 0); check_all();

    // R4: stall overrides slip
    @(negedge clk); md_busy = 1; dcache_miss = 1;
    #2; chk("R4", "stall hold", int'(hold), 5'b11111); check_all();

    // R5: exception at EX over stall and slip
    @(negedge clk); exc_req = 1; exc_stage = 2;
    #2; chk("R5", "exc flush", int'(flush), 5'b00111); check_all();

    // R5: out-of-range stage flushes all
    @(negedge clk); exc_stage = 7;
    #2; chk("R5", "exc flush all", int'(flush), 5'b11111); check_all();

    // R6: taken branch flushes nothing
    @(negedge clk); idle(); br_taken = 1; rf_valid = 1; ex_valid = 1;
    #2; chk("R6", "branch flush", int'(flush), 0); check_all();

    // R7: DC and WB both produce r5
    @(negedge clk); idle(); ex_valid = 1; ex_src_a = 5; ex_src_b = 6;
    dc_valid = 1; dc_we = 1; dc_dst = 5; wb_valid = 1; wb_we = 1; wb_dst = 5;
    #2; chk("R7", "dc priority", int'(byp_a), 1); check_all();
    @(negedge clk); wb_dst = 6;
    #2; chk("R7", "wb select", int'(byp_b), 2); check_all();

    // R8: register 0 with producers naming r0
    @(negedge clk); ex_src_a = 0; dc_dst = 0; wb_dst = 0;
    #2; chk("R8", "zero select", int'(byp_a), 3); check_all();

    // R9: WB write blocked by flush, then by stall
    @(negedge clk); idle(); wb_valid = 1; wb_we = 1; wb_dst = 9;
    #2; chk("R9", "wb write", int'(rf_wr_en), 1); check_all();
    @(negedge clk); exc_req = 1; exc_stage = 4;
    #2; chk("R9", "flushed write", int'(rf_wr_en), 0); check_all();
    @(negedge clk); exc_req = 0; icache_miss = 1;
    #2; chk("R9", "stalled write", int'(rf_wr_en), 0); check_all();

    for (int n = 0; n < 500; n++) begin
      @(negedge clk);
      rf_valid = $urandom % 4 != 0; rf_is_mdmove = $urandom % 4 == 0;
      rf_src_a = 5'($urandom % 4); rf_src_b = 5'($urandom % 4);
      ex_valid = $urandom % 4 != 0; ex_we = $urandom % 3 != 0; ex_is_load = $urandom % 2 == 0;
      ex_src_a = 5'($urandom % 4); ex_src_b = 5'($urandom % 4); ex_dst = 5'($urandom % 4);
      dc_valid = $urandom % 4 != 0; dc_we = $urandom % 3 != 0; dc_dst = 5'($urandom % 4);
      wb_valid = $urandom % 4 != 0; wb_we = $urandom % 3 != 0; wb_dst = 5'($urandom % 4);
      md_busy = $urandom % 2 == 0;
      icache_miss = $urandom % 8 == 0; dcache_miss = $urandom % 8 == 0;
      br_taken = $urandom % 3 == 0;
      exc_req = $urandom % 6 == 0; exc_stage = 3'($urandom % 8);
      #2; check_all();
    end

    @(negedge clk); idle();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule